// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one slow input pin before the rest of the chip sees it. The raw pin is first brought into the fast clock domain through a synchronizer. A filter stage then lets a new level through only after the pin has held that level for a programmed time. The time is measured in ticks of a slow real-time enable, which is a one-cycle pulse in the fast clock domain, nominally at 32.768 kHz. The filter counts only on cycles where that pulse is high.

The debounce span is a 4-bit count multiplied by a tick unit. Two select bits choose the unit, giving windows from about 61 µs up to about 1 s. A 2-bit filter-type field chooses the behaviour:
- Filter both directions of change.
- Let falling edges straight through and filter only rising edges.
- Let rising edges straight through and filter only falling edges.
- Switch filtering off.

A zero count also switches filtering off. The block is meant to sit between a pad input and the edge/level logic that generates interrupts or reads the pin state.

Top module: `debounce_filter`

## Requirements
- R1: While rst_ni is low, level_o is 0 whatever the pin does. The first clock edge after release still shows 0.
- R2: When mode_i is 0 or count_i is 0, level_o follows pin_i unfiltered. A pin change made before clock edge k appears on level_o after edge k+2 (two synchronizer flops plus one output flop).
- R3: The span in ticks is count_i × unit. The unit is chosen by {range_i, unit_i}: 00 gives 2 ticks, 01 gives 8, 10 gives 512, 11 gives 2048.
- R4: With mode_i = 3 (filter both directions), a rise and a fall each need the full span. A tick counts only at an edge where the synchronized level differs from level_o, is unchanged from the previous cycle, and the configuration is unchanged. level_o takes the new value at the edge that samples the span-th counted tick.
- R5: With mode_i = 1 and a nonzero count, a falling pin reaches level_o with the R2 latency. A rising pin needs the full span.
- R6: With mode_i = 2 and a nonzero count, a rising pin reaches level_o with the R2 latency. A falling pin needs the full span.
- R7: Any change of the synchronized level discards the ticks counted so far. A glitch that returns to the current output level before the span completes never reaches level_o.
- R8: A change of count_i, unit_i, range_i or mode_i discards the ticks counted so far. level_o keeps its value until the new span is met.
- R9: In a filtered direction, level_o can change only at an edge where tick_i is high. Without ticks, a held new level never reaches the output.
- R10: When the synchronized level equals level_o, level_o stays put no matter how many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle slow real-time tick enable |
| pin_i | input | 1 | Raw, asynchronous pin level |
| count_i | input | 4 | Debounce count; 0 disables filtering |
| unit_i | input | 1 | Fine unit select (low range bit) |
| range_i | input | 1 | Large range select (high range bit) |
| mode_i | input | 2 | 0 off, 1 pass falls, 2 pass rises, 3 filter both |
| level_o | output | 1 | Filtered pin level |

## Verification
Unfiltered and fast-path changes are due on the third rising edge after the pin moves. The bench samples level_o at the falling edge after the second edge (expecting the old value) and after the third (expecting the new one). Filtered changes are due at the very edge that samples the span-th tick. The bench therefore lets the synchronizer settle for four cycles, drives each tick for exactly one edge, and checks the output after span−1 ticks (unchanged) and again after the span-th tick (changed). Restart cases use the same count-and-sample pattern, so an early or late change by one tick is reported.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    FLT_OFF       = 2'd0,
    FLT_PASS_FALL = 2'd1,
    FLT_PASS_RISE = 2'd2,
    FLT_BOTH      = 2'd3
  } flt_mode_e;

  function automatic int unsigned max4(input int unsigned a, b, c, d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dbf_span.sv
module dbf_span #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SH_00  = 1,
  parameter int unsigned SH_01  = 3,
  parameter int unsigned SH_10  = 9,
  parameter int unsigned SH_11  = 11,
  parameter int unsigned SPAN_W = CNT_W + 11
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic              unit_i,
  input  logic              range_i,
  output logic [SPAN_W-1:0] span_o
);
  timeunit 1ns;
  timeprecision 1ps;

  int unsigned sh;

  always_comb begin
    unique case ({range_i, unit_i})
      2'b00:   sh = SH_00;
      2'b01:   sh = SH_01;
      2'b10:   sh = SH_10;
      default: sh = SH_11;
    endcase
    span_o = SPAN_W'(count_i) << sh;
  end
endmodule

// File: rtl/dbf_core.sv
module dbf_core
  import dbf_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SPAN_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              unit_i,
  input  logic              range_i,
  input  flt_mode_e         mode_i,
  input  logic [SPAN_W-1:0] span_i,
  output logic              level_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CFG_W = CNT_W + 4;

  logic [CFG_W-1:0]  cfg, cfg_q;
  logic [SPAN_W-1:0] cnt_q, cnt_inc;
  logic              sync_d_q, level_q;
  logic              filt_on, differ, fast, restart;

  assign cfg     = {count_i, unit_i, range_i, mode_i};
  assign cnt_inc = cnt_q + 1'b1;
  assign filt_on = (mode_i != FLT_OFF) && (count_i != '0);
  assign differ  = sync_i != level_q;
  // one polarity bypasses the timer in the pass-fall / pass-rise modes
  assign fast    = ((mode_i == FLT_PASS_FALL) && !sync_i) ||
                   ((mode_i == FLT_PASS_RISE) &&  sync_i);
  assign restart = (cfg != cfg_q) || (sync_i != sync_d_q) || !differ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      sync_d_q <= 1'b0;
    end else begin
      cfg_q    <= cfg;
      sync_d_q <= sync_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!filt_on) begin
      level_q <= sync_i;
      cnt_q   <= '0;
    end else if (differ && fast) begin
      level_q <= sync_i;
      cnt_q   <= '0;
    end else if (restart) begin
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (cnt_inc == span_i) begin
        level_q <= sync_i;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_inc;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/debounce_filter.sv
module debounce_filter
  import dbf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SH_00       = 1,
  parameter int unsigned SH_01       = 3,
  parameter int unsigned SH_10       = 9,
  parameter int unsigned SH_11       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             unit_i,
  input  logic             range_i,
  input  logic [1:0]       mode_i,
  output logic             level_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned SH_MAX = max4(SH_00, SH_01, SH_10, SH_11);
  localparam int unsigned SPAN_W = CNT_W + SH_MAX;

  logic              sync_lvl;
  logic [SPAN_W-1:0] span;

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_lvl)
  );

  dbf_span #(
    .CNT_W(CNT_W), .SH_00(SH_00), .SH_01(SH_01),
    .SH_10(SH_10), .SH_11(SH_11), .SPAN_W(SPAN_W)
  ) u_span (
    .count_i (count_i),
    .unit_i  (unit_i),
    .range_i (range_i),
    .span_o  (span)
  );

  dbf_core #(.CNT_W(CNT_W), .SPAN_W(SPAN_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .sync_i  (sync_lvl),
    .count_i (count_i),
    .unit_i  (unit_i),
    .range_i (range_i),
    .mode_i  (flt_mode_e'(mode_i)),
    .span_i  (span),
    .level_o (level_o)
  );
endmodule

// File: rtl/debounce_filter_chk.sv
module debounce_filter_chk
  import dbf_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] count_i,
  input logic [1:0]       mode_i,
  input logic             sync_lvl,
  input logic             level_o
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_RESET_LOW: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !level_o); // R1

  AST_PASS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FLT_OFF || count_i == '0) |=> level_o == $past(sync_lvl)); // R2

  AST_FAST_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FLT_PASS_FALL && count_i != '0 && !sync_lvl) |=> !level_o); // R5

  AST_FAST_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FLT_PASS_RISE && count_i != '0 && sync_lvl) |=> level_o); // R6

  AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FLT_BOTH && count_i != '0 && !tick_i) |=> $stable(level_o)); // R9

  AST_SETTLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == sync_lvl) |=> $stable(level_o)); // R10
endmodule

bind debounce_filter debounce_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .count_i  (count_i),
  .mode_i   (mode_i),
  .sync_lvl (sync_lvl),
  .level_o  (level_o)
);

// File: tb/debounce_filter_test.sv
module debounce_filter_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pin = 1'b0;
  logic [3:0] cnt = 4'd0;
  logic       unit_b = 1'b0;
  logic       range_b = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       level;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  debounce_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pin_i(pin),
    .count_i(cnt), .unit_i(unit_b), .range_i(range_b), .mode_i(mode),
    .level_o(level)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic set_cfg(input logic [3:0] c, input logic r, input logic u, input logic [1:0] m);
    @(negedge clk);
    cnt = c; range_b = r; unit_b = u; mode = m;
    @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic timed(input logic v, input int span, input string req);
    logic old;
    old = level;
    set_pin(v);
    tick_n(span - 1);
    chk(req, level, old);
    tick_n(1);
    chk(req, level, v);
  endtask

  task automatic quick(input logic v, input string req);
    logic old;
    old = level;
    @(negedge clk); pin = v;
    repeat (2) @(negedge clk);
    chk(req, level, old);
    @(negedge clk);
    chk(req, level, v);
  endtask

  task automatic test_reset();
    pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", level, 1'b0);
    rst_n = 1'b1;
    chk("R1", level, 1'b0);
    repeat (5) @(negedge clk);
  endtask

  task automatic test_pass();
    set_cfg(4'd0, 1'b0, 1'b0, 2'd3);
    quick(~level, "R2");
    set_cfg(4'd5, 1'b1, 1'b1, 2'd0);
    quick(~level, "R2");
    repeat (2) @(negedge clk);
  endtask

  task automatic test_units();
    set_cfg(4'd1, 1'b0, 1'b0, 2'd3); timed(~level, 2, "R3");
    set_cfg(4'd1, 1'b0, 1'b1, 2'd3); timed(~level, 8, "R3");
    set_cfg(4'd1, 1'b1, 1'b0, 2'd3); timed(~level, 512, "R3");
    set_cfg(4'd1, 1'b1, 1'b1, 2'd3); timed(~level, 2048, "R3");
    set_cfg(4'd15, 1'b0, 1'b0, 2'd3); timed(~level, 30, "R3");
    set_cfg(4'd3, 1'b0, 1'b1, 2'd3); timed(~level, 24, "R3");
  endtask

  task automatic test_both();
    set_cfg(4'd2, 1'b0, 1'b1, 2'd3);
    timed(1'b1, 16, "R4");
    timed(1'b0, 16, "R4");
  endtask

  task automatic test_pass_fall();
    set_cfg(4'd2, 1'b0, 1'b0, 2'd1);
    set_pin(1'b0);
    chk("R5", level, 1'b0);
    timed(1'b1, 4, "R5");
    quick(1'b0, "R5");
  endtask

  task automatic test_pass_rise();
    set_cfg(4'd2, 1'b0, 1'b0, 2'd2);
    set_pin(1'b1);
    chk("R6", level, 1'b1);
    timed(1'b0, 4, "R6");
    quick(1'b1, "R6");
  endtask

  task automatic test_restart();
    set_cfg(4'd2, 1'b0, 1'b0, 2'd3);
    set_pin(1'b0);
    tick_n(4);
    chk("R7", level, 1'b0);
    set_pin(1'b1);
    tick_n(3);
    set_pin(1'b0);
    set_pin(1'b1);
    tick_n(3);
    chk("R7", level, 1'b0);
    tick_n(1);
    chk("R7", level, 1'b1);
    // one-cycle low glitch while output is high
    @(negedge clk); pin = 1'b0;
    @(negedge clk); pin = 1'b1;
    repeat (4) @(negedge clk);
    tick_n(10);
    chk("R7", level, 1'b1);
  endtask

  task automatic test_cfg_restart();
    set_cfg(4'd2, 1'b0, 1'b0, 2'd3);
    set_pin(1'b0);
    tick_n(3);
    set_cfg(4'd3, 1'b0, 1'b0, 2'd3);
    tick_n(5);
    chk("R8", level, 1'b1);
    tick_n(1);
    chk("R8", level, 1'b0);
  endtask

  task automatic test_no_tick();
    set_cfg(4'd1, 1'b0, 1'b0, 2'd3);
    set_pin(1'b1);
    repeat (50) @(negedge clk);
    chk("R9", level, 1'b0);
    tick_n(2);
    chk("R9", level, 1'b1);
  endtask

  task automatic test_settled();
    tick_n(40);
    chk("R10", level, 1'b1);
    set_cfg(4'd1, 1'b0, 1'b0, 2'd1);
    tick_n(10);
    chk("R10", level, 1'b1);
  endtask

  initial begin
    test_reset();
    test_pass();
    test_units();
    test_both();
    test_pass_fall();
    test_pass_rise();
    test_restart();
    test_cfg_restart();
    test_no_tick();
    test_settled();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule